// File: doc/BRIEF.md
# Manchester ASK Frame Transmitter

This block turns a short byte stream into one radio frame and drives an amplitude-shift-keyed transceiver with it. A frame has five parts in a fixed order. First come three preamble bytes that let the receiver settle its gain. Next is a two-byte start character, whose value depends on whether the sender acts as the network master or as a node. Then the caller's stream follows, which holds the address, the type byte and the payload. Two check bytes close the frame. They come from a mod-255 Fletcher sum that is accumulated while the frame is sent, over every byte except the preamble.

Every data bit is Manchester coded as two half-bits of `HALF_CYC` clock cycles each. The default is 600 cycles, which gives 12 µs at 50 MHz. After every fourth frame byte the block inserts one extra half-bit period that pulls the line low and then high, so the receiver can realign its bit timer. The block drives the two transceiver mode pins and two weighted current outputs. Together these current outputs give a high level, a low but non-zero level, and an idle level. The caller pulses `start_i` with the stream length, then supplies stream bytes over a valid/ready handshake. `done_o` marks the end of the frame.

Top module: `ask_frame_tx`

## Requirements
- R1: A frame sends its bytes in this order: 0xAA three times, then the start character, then exactly `len_i` stream bytes, then check byte c0 and check byte c1. The start character is 0x72,0x65 when `node_i`=0 and 0x6C,0x67 when `node_i`=1.
- R2: Bytes go out LSB first. Each bit takes two half-bits: the first carries the bit value and the second carries its inverse. Each half-bit lasts `HALF_CYC` clock cycles.
- R3: A line level of 1 sets both `ask_hi_o` and `ask_base_o` high. A line level of 0 sets `ask_hi_o` low and `ask_base_o` high. Idle sets both low. `ask_hi_o` is never high while `ask_base_o` is low.
- R4: Two running sums are kept modulo 255 over the start character and the stream: s1 += byte, then s2 += s1. The check bytes are c0 = 255 - ((s1+s2) mod 255) and c1 = 255 - ((s1+c0) mod 255). With `node_i`=0 and the single stream byte 0x00, the check bytes are 0x06, 0x22.
- R5: Bytes are counted from the first preamble byte. After the 4th, 8th, 12th … byte, unless it is the last byte of the frame, one resync half-bit period is inserted. The line is low for the first `HALF_CYC/2` cycles of that period and high for the rest. The resync period does not enter the check sums.
- R6: When no frame is active, both mode pins are high (receive). From the cycle after a start until the end of the frame, `trx_a_o` is low and `trx_b_o` is high (transmit). This transmit window includes one idle half-bit before the first preamble bit and one idle half-bit after the last check bit. The pin pair `trx_a_o`=1, `trx_b_o`=0 never occurs.
- R7: A `start_i` sampled while no frame is active starts a frame in the next cycle, and `node_i` and `len_i` are captured at that edge. A `start_i` pulse during an active frame has no effect on the frame.
- R8: `done_o` is a one-cycle pulse. It appears in the cycle right after the trailing idle half-bit, and in that same cycle the mode pins return to receive.
- R9: `ready_o` is high only during an active frame while stream bytes are still outstanding. Exactly `len_i` bytes are accepted per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for a frame |
| node_i | input | 1 | Selects the start character: 0 for master, 1 for node |
| len_i | input | LEN_W | Number of stream bytes (address, type and payload) |
| data_i | input | 8 | Stream byte |
| valid_i | input | 1 | Stream byte is valid |
| ready_o | output | 1 | Block takes a stream byte in this cycle |
| done_o | output | 1 | Pulse at the end of the frame |
| ask_hi_o | output | 1 | Weighted ASK drive, high-current leg |
| ask_base_o | output | 1 | Weighted ASK drive, base-current leg |
| trx_a_o | output | 1 | Transceiver mode pin A |
| trx_b_o | output | 1 | Transceiver mode pin B |

## Verification
Every frame is compared cycle by cycle with a waveform the bench builds from the requirements, with `HALF_CYC` reduced to 4. Mismatches are counted separately for the frame bytes, the check bytes, the resync periods and the mode pins. The directed wake frame checks the check sums against the fixed bytes 0x06, 0x22 rather than against the bench's own sum. A frame of all 0xFF bytes drives the mod-255 wrap at its largest input. Frames of length 0 and 20 move the resync points across the start character, the stream and the check bytes. Random frames alternate the two start characters. One frame receives an extra start pulse in the middle, which must leave its waveform unchanged.

// File: rtl/ask_tx_pkg.sv
package ask_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_BITS, ST_SYNC, ST_WAIT, ST_TAIL
  } tx_state_e;

  localparam logic [7:0] PRE_BYTE = 8'hAA;
  localparam int unsigned PRE_LEN = 3;
  localparam logic [7:0] SC_MST0 = 8'h72;
  localparam logic [7:0] SC_MST1 = 8'h65;
  localparam logic [7:0] SC_NOD0 = 8'h6C;
  localparam logic [7:0] SC_NOD1 = 8'h67;

  // a in 0..254, b in 0..255
  function automatic logic [7:0] add255(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s >= 9'd255) ? 8'(s - 9'd255) : s[7:0];
  endfunction
endpackage

// File: rtl/ask_tx_timer.sv
module ask_tx_timer #(
  parameter int unsigned HALF_CYC = 600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o,
  output logic [$clog2(HALF_CYC+1)-1:0] cnt_o
);
  localparam int unsigned CNT_W = $clog2(HALF_CYC+1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CNT_MAX);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ask_tx_fletcher.sv
module ask_tx_fletcher
  import ask_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       add_i,
  input  logic [7:0] byte_i,
  output logic [7:0] c0_o,
  output logic [7:0] c1_o
);
  logic [7:0] s1_q, s2_q, s1_n;

  assign s1_n = add255(s1_q, byte_i);
  assign c0_o = 8'd255 - add255(s1_q, s2_q);
  assign c1_o = 8'd255 - add255(s1_q, c0_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else if (clr_i) begin
      s1_q <= '0;
      s2_q <= '0;
    end else if (add_i) begin
      s1_q <= s1_n;
      s2_q <= add255(s2_q, s1_n);
    end
  end
endmodule

// File: rtl/ask_frame_tx.sv
module ask_frame_tx
  import ask_tx_pkg::*;
#(
  parameter int unsigned HALF_CYC = 600,
  parameter int unsigned LEN_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             node_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       data_i,
  input  logic             valid_i,
  output logic             ready_o,
  output logic             done_o,
  output logic             ask_hi_o,
  output logic             ask_base_o,
  output logic             trx_a_o,
  output logic             trx_b_o
);
  localparam int unsigned IDX_W = LEN_W + 2;
  localparam int unsigned CNT_W = $clog2(HALF_CYC+1);
  localparam logic [CNT_W-1:0] SYNC_HI = CNT_W'(HALF_CYC / 2);

  tx_state_e        state_q;
  logic [IDX_W-1:0] idx_q, nidx, len_ext, last_idx;
  logic [LEN_W-1:0] len_q, left_q;
  logic             node_q, ph_q, hold_v_q, done_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q, hold_q, sel_byte, c0, c1;
  logic             tick, run, accept, byte_end, is_stream, load_pt, go, stall, fl_add;
  logic [CNT_W-1:0] cnt;
  logic             drive, lvl;

  assign run = (state_q == ST_LEAD) || (state_q == ST_BITS) ||
               (state_q == ST_SYNC) || (state_q == ST_TAIL);

  ask_tx_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk_i, .rst_ni, .run_i(run), .tick_o(tick), .cnt_o(cnt)
  );

  assign len_ext   = IDX_W'(len_q);
  assign last_idx  = len_ext + IDX_W'(6);
  assign nidx      = idx_q + 1'b1;
  assign is_stream = (nidx >= IDX_W'(5)) && (nidx < len_ext + IDX_W'(5));
  assign byte_end  = (state_q == ST_BITS) && tick && ph_q && (bit_q == 3'd7);

  always_comb begin
    if (nidx < IDX_W'(PRE_LEN))         sel_byte = PRE_BYTE;
    else if (nidx == IDX_W'(3))          sel_byte = node_q ? SC_NOD0 : SC_MST0;
    else if (nidx == IDX_W'(4))          sel_byte = node_q ? SC_NOD1 : SC_MST1;
    else if (is_stream)                  sel_byte = hold_q;
    else if (nidx == len_ext + IDX_W'(5)) sel_byte = c0;
    else                                 sel_byte = c1;
  end

  // points where the next frame byte is needed
  assign load_pt = ((state_q == ST_LEAD) && tick) ||
                   (byte_end && (idx_q != last_idx) && (idx_q[1:0] != 2'b11)) ||
                   ((state_q == ST_SYNC) && tick) ||
                   (state_q == ST_WAIT);
  assign go     = load_pt && (!is_stream || hold_v_q);
  assign stall  = load_pt && is_stream && !hold_v_q;
  assign fl_add = go && (nidx >= IDX_W'(3)) && (nidx < len_ext + IDX_W'(5));

  ask_tx_fletcher u_fletch (
    .clk_i, .rst_ni,
    .clr_i ((state_q == ST_IDLE) && start_i),
    .add_i (fl_add),
    .byte_i(sel_byte),
    .c0_o  (c0),
    .c1_o  (c1)
  );

  assign ready_o = (state_q != ST_IDLE) && !hold_v_q && (left_q != '0);
  assign accept  = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '1;
      len_q    <= '0;
      left_q   <= '0;
      node_q   <= 1'b0;
      sh_q     <= '0;
      bit_q    <= '0;
      ph_q     <= 1'b0;
      hold_q   <= '0;
      hold_v_q <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      if (start_i) begin
        state_q  <= ST_LEAD;
        idx_q    <= '1;
        len_q    <= len_i;
        left_q   <= len_i;
        node_q   <= node_i;
        hold_v_q <= 1'b0;
      end
    end else begin
      if (go && is_stream) hold_v_q <= 1'b0;
      if (accept) begin
        hold_q   <= data_i;
        hold_v_q <= 1'b1;
        left_q   <= left_q - 1'b1;
      end
      if (go) begin
        sh_q    <= sel_byte;
        bit_q   <= '0;
        ph_q    <= 1'b0;
        idx_q   <= nidx;
        state_q <= ST_BITS;
      end else if (stall) begin
        state_q <= ST_WAIT;
      end else if ((state_q == ST_BITS) && tick) begin
        if (!ph_q) begin
          ph_q <= 1'b1;
        end else begin
          ph_q <= 1'b0;
          if (bit_q != 3'd7) begin
            bit_q <= bit_q + 1'b1;
            sh_q  <= sh_q >> 1;
          end else if (idx_q == last_idx) begin
            state_q <= ST_TAIL;
          end else begin
            state_q <= ST_SYNC;
          end
        end
      end else if ((state_q == ST_TAIL) && tick) begin
        state_q <= ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= (state_q == ST_TAIL) && tick;
  end

  always_comb begin
    drive = 1'b1;
    lvl   = 1'b0;
    unique case (state_q)
      ST_BITS: lvl = sh_q[0] ^ ph_q;
      ST_SYNC: lvl = (cnt >= SYNC_HI);
      ST_WAIT: lvl = 1'b0;
      default: drive = 1'b0;
    endcase
  end

  assign ask_hi_o   = drive && lvl;
  assign ask_base_o = drive;
  assign trx_a_o    = (state_q == ST_IDLE);
  assign trx_b_o    = 1'b1;
  assign done_o     = done_q;
endmodule

// File: rtl/ask_frame_tx_chk.sv
module ask_frame_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ready_o,
  input logic done_o,
  input logic ask_hi_o,
  input logic ask_base_o,
  input logic trx_a_o,
  input logic trx_b_o
);
  AST_ASK_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ask_hi_o && !ask_base_o)); // R3
  AST_RX_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trx_a_o && trx_b_o) |-> !ask_base_o); // R6
  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trx_a_o && !trx_b_o)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (trx_a_o && trx_b_o)); // R8
  AST_READY_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!trx_a_o && trx_b_o)); // R9
endmodule

bind ask_frame_tx ask_frame_tx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ready_o(ready_o), .done_o(done_o),
  .ask_hi_o(ask_hi_o), .ask_base_o(ask_base_o),
  .trx_a_o(trx_a_o), .trx_b_o(trx_b_o)
);

// File: tb/ask_frame_tx_tb.sv
module ask_frame_tx_tb;
  localparam int HALF  = 4;
  localparam int LEN_W = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, node_i = 1'b0, valid_i = 1'b0;
  logic [LEN_W-1:0] len_i = '0;
  logic [7:0] data_i = '0;
  logic ready_o, done_o, ask_hi_o, ask_base_o, trx_a_o, trx_b_o;

  int n_tests = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  ask_frame_tx #(.HALF_CYC(HALF), .LEN_W(LEN_W)) u_dut (
    .clk_i, .rst_ni, .start_i, .node_i, .len_i, .data_i, .valid_i,
    .ready_o, .done_o, .ask_hi_o, .ask_base_o, .trx_a_o, .trx_b_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void fletch(input logic [7:0] b[$], output logic [7:0] c0, output logic [7:0] c1);
    int s1 = 0, s2 = 0;
    foreach (b[i]) begin
      s1 = (s1 + b[i]) % 255;
      s2 = (s2 + s1) % 255;
    end
    c0 = 8'(255 - ((s1 + s2) % 255));
    c1 = 8'(255 - ((s1 + c0) % 255));
  endfunction

  // sym codes: 0 idle-tx, 1 high, 2 low, 3 resync; tag: 1 frame byte, 4 check byte, 5 resync, 6 idle
  task automatic run_frame(input bit node, input logic [7:0] strm[$], input bit wake_lit, input bit mid_start);
    logic [7:0] fr[$], sumq[$];
    logic [7:0] c0, c1;
    int syms[$], tags[$];
    int e_byte = 0, e_chk = 0, e_sync = 0, e_mode = 0, e_done = 0, acc = 0;
    int n = strm.size();
    fr = {8'hAA, 8'hAA, 8'hAA};
    fr.push_back(node ? 8'h6C : 8'h72);
    fr.push_back(node ? 8'h67 : 8'h65);
    sumq = {fr[3], fr[4]};
    foreach (strm[i]) begin fr.push_back(strm[i]); sumq.push_back(strm[i]); end
    fletch(sumq, c0, c1);
    if (wake_lit) begin c0 = 8'h06; c1 = 8'h22; end  // R4 fixed values
    fr.push_back(c0);
    fr.push_back(c1);
    syms.push_back(0); tags.push_back(6);
    foreach (fr[i]) begin
      for (int b = 0; b < 8; b++) begin
        bit v = fr[i][b];
        int t = (i >= fr.size() - 2) ? 4 : 1;
        syms.push_back(v ? 1 : 2); tags.push_back(t);
        syms.push_back(v ? 2 : 1); tags.push_back(t);
      end
      if ((i % 4) == 3 && i != fr.size() - 1) begin syms.push_back(3); tags.push_back(5); end
    end
    syms.push_back(0); tags.push_back(6);

    @(negedge clk_i);
    start_i = 1'b1; node_i = node; len_i = LEN_W'(n);
    @(negedge clk_i);
    start_i = 1'b0; node_i = ~node; len_i = '0;
    fork
      begin
        for (int k = 0; k < n; ) begin
          bit r;
          valid_i = 1'b1; data_i = strm[k];
          r = ready_o;
          @(posedge clk_i);
          if (r) begin k++; acc++; end
          @(negedge clk_i);
        end
        valid_i = 1'b0;
      end
      begin
        foreach (syms[s]) begin
          for (int j = 0; j < HALF; j++) begin
            bit eh, eb;
            case (syms[s])
              0: begin eh = 0; eb = 0; end
              1: begin eh = 1; eb = 1; end
              2: begin eh = 0; eb = 1; end
              default: begin eh = (j >= HALF / 2); eb = 1; end
            endcase
            if (ask_hi_o !== eh || ask_base_o !== eb) begin
              if (tags[s] == 4) e_chk++;
              else if (tags[s] == 5) e_sync++;
              else e_byte++;
            end
            if (trx_a_o !== 1'b0 || trx_b_o !== 1'b1) e_mode++;
            if (done_o !== 1'b0) e_done++;
            if (mid_start && s == 40) start_i = (j == 0);  // R7 ignored while busy
            @(negedge clk_i);
          end
        end
        start_i = 1'b0;
      end
    join
    chk(e_byte == 0, mid_start ? "R7 R1 R2 R3 frame bytes" : "R1 R2 R3 frame bytes", e_byte, 0);
    chk(e_chk == 0, wake_lit ? "R4 wake check bytes" : "R4 check bytes", e_chk, 0);
    chk(e_sync == 0, "R5 resync", e_sync, 0);
    chk(e_mode == 0, "R6 transmit mode", e_mode, 0);
    chk(e_done == 0 && done_o === 1'b1 && trx_a_o === 1'b1 && trx_b_o === 1'b1,
        "R8 done with receive mode", {e_done, done_o, trx_a_o}, 1);
    chk(acc == n, "R9 bytes accepted", acc, n);
    @(negedge clk_i);
    chk(done_o === 1'b0 && ready_o === 1'b0 && ask_base_o === 1'b0, "R8 R9 after done",
        {done_o, ready_o, ask_base_o}, 0);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] q[$];
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk_i);
    chk(ask_hi_o === 0 && ask_base_o === 0 && trx_a_o === 1 && trx_b_o === 1 &&
        ready_o === 0 && done_o === 0, "R6 R9 reset state",
        {ask_hi_o, ask_base_o, trx_a_o, trx_b_o, ready_o, done_o}, 6'b001100);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    q = {8'h00};
    run_frame(1'b0, q, 1'b1, 1'b0);          // wake frame, R4
    q = {};
    run_frame(1'b1, q, 1'b0, 1'b0);          // empty stream, node start
    q = {};
    repeat (9) q.push_back(8'hFF);
    run_frame(1'b0, q, 1'b0, 1'b0);          // mod-255 wrap
    q = {};
    for (int i = 0; i < 20; i++) q.push_back(8'($urandom));
    run_frame(1'b1, q, 1'b0, 1'b1);          // long, start pulsed mid-frame
    for (int f = 0; f < 6; f++) begin
      int l = $urandom_range(1, 12);
      q = {};
      for (int i = 0; i < l; i++) q.push_back(8'($urandom));
      run_frame(1'($urandom), q, 1'b0, 1'b0);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule